// File: doc/BRIEF.md
# Redundant-Form Fixed-Modulus Modular Squarer

This block squares an integer held in a redundant digit form and folds the wide square back modulo a constant odd modulus `M`. `M` is fixed at elaboration. The operand has `N+1` coefficients. Each coefficient is `W+1` bits wide, which is one bit more than a digit, and coefficient `i` carries weight `2^(i*W)`. The result uses the same form, so it can be fed straight back in as the next input in a chain of repeated squarings. Carries never travel further than one coefficient product. Conversion to plain binary and the final step into `[0, M)` are left to the user.

Inside the block, each coefficient product is formed once: diagonal products are taken once, and each cross product is taken once and doubled. Every product bit whose weight is `2^K` or higher (`K = N*W`) selects a constant `2^pos mod M` or zero. The low product bits and these selected constants go into a log-depth carry-save tree. The tree's sum and carry vectors are then added coefficient by coefficient. Each coefficient keeps its own overflow bit, so no carry crosses a coefficient boundary. When `PIPE=1`, a register stage sits at the output.

Top module: `msq_square`

## Requirements
- R1: `sq_in` holds `N+1` coefficients, coefficient `i` in bits `[i*(W+1) +: W+1]` with weight `2^(i*W)`. The integer read from `sq_out` the same way is congruent modulo `M` to the square of the integer read from `sq_in`. This holds for any coefficient values, including those whose top (redundant) bit is set.
- R2: An all-zero `sq_in` yields an all-zero `sq_out`.
- R3: The integer value of `sq_out` stays below `T*2^K`, where `T` is `N` plus the count of product-coefficient bits of weight `2^K` or more. For the default `W=8`, `N=3`, that bound is `99*2^24`. Parameter sets that cannot keep the result inside the output form are rejected at elaboration.
- R4: With every input coefficient at its maximum `2^(W+1)-1`, the output is still congruent to the input's square modulo `M`.
- R5: With `PIPE=1`, `sq_out` reflects the `sq_in` sampled at the previous rising edge of `clk`. It does not change between edges, and it stays unchanged while `sq_in` is held.
- R6: With `PIPE=1`, a low `rst_n` clears `sq_out` to zero at once, whatever `sq_in` is.
- R7: Take two inputs that encode the same integer in different ways: one has the redundant bit of coefficient `i` set, the other has coefficient `i+1` one larger and that bit clear. Their outputs are congruent to each other modulo `M`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| sq_in | input | (N+1)*(W+1) | Operand coefficients, coefficient 0 in the low bits |
| sq_out | output | (N+1)*(W+1) | Reduced square in the same redundant form |

## Verification
Each coefficient position is driven alone through all of its `2^(W+1)` values. These single-coefficient sweeps expose a wrong weight, a dropped cross-product doubling, or a wrong reduction constant for one specific bit position. Random full vectors then mix all the cross products at once. Zero and all-maximum inputs probe the two ends of the range and the tightest overflow case. Pairs of equal integers written with and without a set redundant bit show whether that bit is honoured at its true weight. Timing checks around an input change and a mid-run reset separate the registered path from a combinational leak.

// File: rtl/msq_pkg.sv
package msq_pkg;

   // width of one product coefficient: up to NC products of (W+1)-bit values
   function automatic int prod_width(input int w, input int nc);
      return 2*w + 2 + $clog2(nc);
   endfunction

   // number of product-coefficient bits with weight at or above 2^(n*w)
   function automatic int red_count(input int w, input int n, input int pcw);
      int cnt;
      cnt = 0;
      for (int m = 0; m < 2*n+1; m++)
         for (int b = 0; b < pcw; b++)
            if (m*w + b >= n*w) cnt++;
      return cnt;
   endfunction

   // position of bit (m0,b0) among the reduced bits, column-major order
   function automatic int red_index(input int w, input int n, input int pcw,
                                    input int m0, input int b0);
      int cnt;
      cnt = 0;
      for (int m = 0; m < 2*n+1; m++)
         for (int b = 0; b < pcw; b++)
            if ((m*w + b >= n*w) && ((m < m0) || (m == m0 && b < b0))) cnt++;
      return cnt;
   endfunction

   // bits of product coefficient m that stay below the reduction boundary
   function automatic int low_bits(input int w, input int n, input int pcw, input int m);
      int lim;
      lim = (n - m) * w;
      return (lim < pcw) ? lim : pcw;
   endfunction

   // operand count after lvl levels of 3:2 compression
   function automatic int tree_level_count(input int nt, input int lvl);
      int c;
      c = nt;
      for (int l = 0; l < lvl; l++) c = 2*(c/3) + (c%3);
      return c;
   endfunction

   function automatic int tree_depth(input int nt);
      int c;
      int d;
      c = nt;
      d = 0;
      while (c > 2) begin
         c = 2*(c/3) + (c%3);
         d++;
      end
      return d;
   endfunction

   // 2^pos mod m by repeated doubling
   function automatic logic [63:0] pow2_mod(input int pos, input logic [63:0] m);
      logic [63:0] r;
      r = 64'd1;
      for (int i = 0; i < pos; i++) begin
         r = r << 1;
         if (r >= m) r = r - m;
      end
      return r;
   endfunction

endpackage

// File: rtl/msq_coef_prod.sv
module msq_coef_prod #(
   parameter int CW  = 9,
   parameter int NC  = 4,
   parameter int PCW = 20
) (
   input  logic [CW-1:0]  coef_i [NC],
   output logic [PCW-1:0] pc_o   [2*NC-1]
);
   localparam int NPC = 2*NC - 1;

   for (genvar m = 0; m < NPC; m++) begin : g_col
      logic [PCW-1:0] acc;
      always_comb begin
         acc = '0;
         for (int i = 0; i < NC; i++)
            for (int j = i; j < NC; j++)
               if (i + j == m) begin
                  if (i == j)
                     acc = acc + PCW'(coef_i[i]) * PCW'(coef_i[j]);
                  else
                     acc = acc + ((PCW'(coef_i[i]) * PCW'(coef_i[j])) << 1);
               end
      end
      assign pc_o[m] = acc;
   end
endmodule

// File: rtl/msq_csa_tree.sv
module msq_csa_tree
   import msq_pkg::*;
#(
   parameter int TW = 33,
   parameter int NT = 99
) (
   input  logic [TW-1:0] terms_i [NT],
   output logic [TW-1:0] sum_o,
   output logic [TW-1:0] carry_o
);
   localparam int DEPTH = tree_depth(NT);
   localparam int FINAL = tree_level_count(NT, DEPTH);

   if (NT < 3) begin : g_err_nt
      $error("msq_csa_tree: at least three operands required");
   end

   logic [TW-1:0] cur [NT];
   logic [TW-1:0] nxt [NT];

   always_comb begin
      int n;
      int g3;
      cur = terms_i;
      nxt = terms_i;
      for (int l = 0; l < DEPTH; l++) begin
         n   = tree_level_count(NT, l);
         g3  = n / 3;
         nxt = cur;
         for (int g = 0; g < g3; g++) begin
            nxt[2*g]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
            nxt[2*g+1] = ((cur[3*g] & cur[3*g+1]) | (cur[3*g] & cur[3*g+2]) |
                          (cur[3*g+1] & cur[3*g+2])) << 1;
         end
         for (int r = 0; r < n % 3; r++)
            nxt[2*g3 + r] = cur[3*g3 + r];
         cur = nxt;
      end
      sum_o   = cur[0];
      carry_o = (FINAL > 1) ? cur[1] : '0;
   end
endmodule

// File: rtl/msq_coef_resolve.sv
module msq_coef_resolve #(
   parameter int W  = 8,
   parameter int NC = 4,
   parameter int TW = NC*W + 1
) (
   input  logic [TW-1:0]        sum_i,
   input  logic [TW-1:0]        carry_i,
   output logic [NC*(W+1)-1:0]  coef_o
);
   localparam int CW = W + 1;

   if (TW != NC*W + 1) begin : g_err_tw
      $error("msq_coef_resolve: TW must equal NC*W+1");
   end

   for (genvar i = 0; i < NC; i++) begin : g_coef
      if (i < NC - 1) begin : g_mid
         // digit add; overflow stays in this coefficient's extra bit
         assign coef_o[i*CW +: CW] = {1'b0, sum_i[i*W +: W]} + {1'b0, carry_i[i*W +: W]};
      end else begin : g_top
         // top coefficient spans W+1 tree bits; sum wraps modulo 2^TW
         assign coef_o[i*CW +: CW] = sum_i[i*W +: CW] + carry_i[i*W +: CW];
      end
   end
endmodule

// File: rtl/msq_square.sv
module msq_square
   import msq_pkg::*;
#(
   parameter int          W    = 8,
   parameter int          N    = 3,
   parameter logic [63:0] M    = 64'd16777213,
   parameter int          PIPE = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [(N+1)*(W+1)-1:0] sq_in,
   output logic [(N+1)*(W+1)-1:0] sq_out
);
   localparam int NC   = N + 1;
   localparam int CW   = W + 1;
   localparam int K    = N * W;
   localparam int PCW  = prod_width(W, NC);
   localparam int NPC  = 2*NC - 1;
   localparam int NRED = red_count(W, N, PCW);
   localparam int NT   = N + NRED;
   localparam int TW   = NC*W + 1;

   // ---------------- elaboration checks ----------------
   if (W < 2) begin : g_err_w
      $error("msq_square: digit width must be at least 2");
   end
   if (N < 1) begin : g_err_n
      $error("msq_square: at least one digit required");
   end
   if (K > 62) begin : g_err_k
      $error("msq_square: modulus width above 62 bits not supported");
   end
   if (M[0] != 1'b1 || M < 64'd3) begin : g_err_odd
      $error("msq_square: modulus must be odd and at least 3");
   end
   if ((M >> K) != 64'd0) begin : g_err_mw
      $error("msq_square: modulus wider than N*W bits");
   end
   if (K + $clog2(NT) > TW) begin : g_err_fit
      $error("msq_square: reduced sum cannot fit the redundant output form");
   end
   if (PIPE != 0 && PIPE != 1) begin : g_err_pipe
      $error("msq_square: PIPE must be 0 or 1");
   end

   // ---------------- unpack ----------------
   logic [CW-1:0] coef [NC];
   for (genvar i = 0; i < NC; i++) begin : g_unpack
      assign coef[i] = sq_in[i*CW +: CW];
   end

   // ---------------- product coefficients ----------------
   logic [PCW-1:0] pc [NPC];
   msq_coef_prod #(.CW(CW), .NC(NC), .PCW(PCW)) u_prod (
      .coef_i (coef),
      .pc_o   (pc)
   );

   // ---------------- low terms and constant reduction selects ----------------
   logic [TW-1:0] terms [NT];
   for (genvar m = 0; m < NPC; m++) begin : g_col
      if (m < N) begin : g_low
         localparam int LB = low_bits(W, N, PCW, m);
         assign terms[m] = TW'(pc[m][LB-1:0]) << (m*W);
      end
      for (genvar b = 0; b < PCW; b++) begin : g_bit
         if (m*W + b >= K) begin : g_red
            localparam int            IDX = N + red_index(W, N, PCW, m, b);
            localparam logic [TW-1:0] RV  = TW'(pow2_mod(m*W + b, M));
            assign terms[IDX] = pc[m][b] ? RV : '0;
         end
      end
   end

   // ---------------- compression and per-coefficient resolve ----------------
   logic [TW-1:0] tsum;
   logic [TW-1:0] tcar;
   msq_csa_tree #(.TW(TW), .NT(NT)) u_tree (
      .terms_i (terms),
      .sum_o   (tsum),
      .carry_o (tcar)
   );

   logic [NC*CW-1:0] res;
   msq_coef_resolve #(.W(W), .NC(NC), .TW(TW)) u_res (
      .sum_i   (tsum),
      .carry_i (tcar),
      .coef_o  (res)
   );

   // ---------------- optional output stage ----------------
   if (PIPE == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sq_out <= '0;
         else        sq_out <= res;
      end
   end else begin : g_comb
      assign sq_out = res;
   end
endmodule

// File: rtl/msq_square_chk.sv
module msq_square_chk
   import msq_pkg::*;
#(
   parameter int          W    = 8,
   parameter int          N    = 3,
   parameter logic [63:0] M    = 64'd16777213,
   parameter int          PIPE = 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [(N+1)*(W+1)-1:0] sq_in,
   input logic [(N+1)*(W+1)-1:0] sq_out
);
   localparam int NC  = N + 1;
   localparam int CW  = W + 1;
   localparam int K   = N * W;
   localparam int PCW = prod_width(W, NC);
   localparam int NT  = N + red_count(W, N, PCW);
   localparam int VW  = 2*(NC*W + 2);
   localparam logic [VW-1:0] BOUND = VW'(NT) << K;
   localparam logic [VW-1:0] MV    = VW'(M);

   function automatic logic [VW-1:0] to_int(input logic [NC*CW-1:0] v);
      logic [VW-1:0] r;
      r = '0;
      for (int i = 0; i < NC; i++) r = r + (VW'(v[i*CW +: CW]) << (i*W));
      return r;
   endfunction

   logic [VW-1:0] in_val, out_val, in_sq_mod, out_mod;
   always_comb begin
      in_val    = to_int(sq_in);
      out_val   = to_int(sq_out);
      in_sq_mod = (in_val * in_val) % MV;
      out_mod   = out_val % MV;
   end

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_val < BOUND);

   if (PIPE == 1) begin : g_seq
      assert_congruent_R1: assert property (@(posedge clk) disable iff (!rst_n)
         armed |-> out_mod == $past(in_sq_mod));
      assert_zero_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(in_val) == '0) |-> out_val == '0);
      assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $stable(sq_in)) |=> $stable(sq_out));
   end else begin : g_cmb
      assert_congruent_R1: assert property (@(posedge clk) disable iff (!rst_n)
         armed |-> out_mod == in_sq_mod);
      assert_zero_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && in_val == '0) |-> out_val == '0);
      assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $stable(sq_in)) |-> $stable(sq_out));
   end
endmodule

bind msq_square msq_square_chk #(.W(W), .N(N), .M(M), .PIPE(PIPE)) u_msq_chk (.*);

// File: tb/test_msq_square.sv
module test_msq_square;
   localparam int          W  = 8;
   localparam int          N  = 3;
   localparam int          NC = N + 1;
   localparam int          CW = W + 1;
   localparam int          K  = N * W;
   localparam logic [63:0] M  = 64'd16777213;
   localparam int          VW = 80;
   localparam logic [VW-1:0] MV    = VW'(M);
   localparam logic [VW-1:0] BOUND = VW'(99) << K;   // R3 bound for this configuration

   logic             clk = 1'b0;
   logic             rst_n;
   logic [NC*CW-1:0] sq_in;
   logic [NC*CW-1:0] sq_out;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   msq_square #(.W(W), .N(N), .M(M), .PIPE(1)) i_msq_square (
      .clk    (clk),
      .rst_n  (rst_n),
      .sq_in  (sq_in),
      .sq_out (sq_out)
   );

   function automatic logic [VW-1:0] to_int(input logic [NC*CW-1:0] v);
      logic [VW-1:0] r;
      r = '0;
      for (int i = 0; i < NC; i++) r = r + (VW'(v[i*CW +: CW]) << (i*W));
      return r;
   endfunction

   function automatic logic [VW-1:0] sq_mod(input logic [NC*CW-1:0] v);
      logic [VW-1:0] a;
      a = to_int(v);
      return (a * a) % MV;
   endfunction

   function automatic logic [NC*CW-1:0] rnd_vec();
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      return r[NC*CW-1:0];
   endfunction

   task automatic check_eq(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic check_below(input string req, input logic [VW-1:0] got);
      n_vec++;
      if (!(got < BOUND)) begin
         n_bad++;
         $display("FAIL %s: got %0d expected below %0d", req, got, BOUND);
      end
   endtask

   // drive at a falling edge, result is registered at the next rising edge
   task automatic apply(input string req, input logic [NC*CW-1:0] v);
      @(negedge clk) sq_in = v;
      @(negedge clk);
      check_eq(req, to_int(sq_out) % MV, sq_mod(v));
      check_below("R3", to_int(sq_out));
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [NC*CW-1:0] va, vb;
      logic [VW-1:0]    ra, rb, held;
      rst_n = 1'b1;
      sq_in = '1;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_eq("R6 reset value", to_int(sq_out), '0);
      @(negedge clk) rst_n = 1'b1;

      // R2: zero squares to zero exactly
      apply("R2", '0);
      check_eq("R2 exact zero", to_int(sq_out), '0);

      // R4: every coefficient at its maximum
      apply("R4", '1);

      // R1: each coefficient alone through its full range
      for (int i = 0; i < NC; i++)
         for (int v = 0; v < (1 << CW); v++) begin
            va = '0;
            va[i*CW +: CW] = CW'(v);
            apply("R1 single coefficient", va);
         end

      // R1: random full-width vectors
      for (int t = 0; t < 2000; t++) apply("R1 random", rnd_vec());

      // R7: same integer with and without the redundant bit set
      for (int i = 0; i < NC-1; i++)
         for (int s = 0; s < 64; s++) begin
            va = rnd_vec();
            va[i*CW +: CW]     = CW'(9'h100 | ($urandom() % 256));
            va[(i+1)*CW +: CW] = CW'($urandom() % 511);
            vb = va;
            vb[i*CW +: CW]     = va[i*CW +: CW] - CW'(9'h100);
            vb[(i+1)*CW +: CW] = va[(i+1)*CW +: CW] + CW'(1);
            apply("R7 encoding A", va);
            ra = to_int(sq_out) % MV;
            apply("R7 encoding B", vb);
            rb = to_int(sq_out) % MV;
            check_eq("R7 encodings agree", rb, ra);
         end

      // R5: output changes only at the edge after an input change, then holds
      va = rnd_vec();
      vb = rnd_vec();
      apply("R5 first", va);
      @(negedge clk) sq_in = vb;
      #2 check_eq("R5 before edge", to_int(sq_out) % MV, sq_mod(va));
      @(negedge clk);
      check_eq("R5 after edge", to_int(sq_out) % MV, sq_mod(vb));
      held = to_int(sq_out);
      repeat (3) @(negedge clk);
      check_eq("R5 held input", to_int(sq_out), held);

      // R6: asynchronous clear in the middle of a run
      apply("R6 before reset", '1);
      @(negedge clk) rst_n = 1'b0;
      #2 check_eq("R6 async clear", to_int(sq_out), '0);
      @(negedge clk) rst_n = 1'b1;
      apply("R6 after release", vb);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule